// File: doc/BRIEF.md
# DDR2 Burst Write Sequencer

This block sequences a single DDR2 burst write from the controller side. A client offers a request made of a bank, a starting column, up to eight data words with per-word byte enables, and a burst-length choice. On acceptance, the block puts the column-write command on the control pins and counts the write latency. The write latency is the posted additive latency plus the CAS latency minus one. The block then drives a one-clock low preamble on the strobe, followed by strobe toggles carrying the data beats and a half-clock postamble. It waits out write recovery and issues a single-bank precharge to the bank it wrote. A one-cycle done pulse ends the sequence.

Double-data-rate behaviour is modelled at the clock rate. Each strobe, data and mask signal comes as a pair of values: one for the first half of the clock period, after the rising edge, and one for the second half, after the falling edge. Separate output enables stand in for the tristate drivers. A pad wrapper turns these pairs into real pin activity.

The state machine has eight states: IDLE (ready), WRCMD (command cycle), WAIT (latency count), PREAMB (preamble), BURST (one cycle per beat pair), POSTAM (postamble), RECOV (write recovery) and PCHG (precharge and done). The transitions are:

- IDLE→WRCMD on accept.
- WRCMD→WAIT, or WRCMD→PREAMB when the latency is two.
- WAIT→PREAMB when the latency count expires.
- PREAMB→BURST.
- BURST→POSTAM after the last pair.
- POSTAM→RECOV, or POSTAM→PCHG when the recovery time is one.
- RECOV→PCHG when the recovery count expires.
- PCHG→IDLE.

Top module: `ddr2_wr_seq`

## Requirements
In the requirements below, WL = AL + CL − 1. Cycle numbers count clock cycles after the WRITE cycle, which is cycle 0. BL is the number of beats.

- R1: The WRITE cycle is the cycle after a request is accepted. During it the control pins are cs_n=0, ras_n=1, cas_n=0 and we_n=0. `ba` carries the bank, `addr[COL_W-1:0]` carries the column, and all other `addr` bits are 0, so bit 10 is low.
- R2: Every cycle that carries no WRITE or PRECHARGE drives NOP (cs_n=0, ras_n=cas_n=we_n=1), with `ba` and `addr` at 0.
- R3: Cycle WL−1 is the preamble. Both strobe half-enables are 1, both strobe halves are 0, and `dq_oe` is 0.
- R4: Cycles WL to WL+BL/2−1 carry the beats. In cycle WL+i the strobe is high in the first half and low in the second. `dq_rise` carries word 2i and `dq_fall` carries word 2i+1, where word k is `req_data[k*DW +: DW]`. `dq_oe` is 1 only in these cycles, and the data outputs are 0 whenever `dq_oe` is 0.
- R5: `req_bl8` is sampled at acceptance. A value of 1 gives 8 beats (4 BURST cycles) and a value of 0 gives 4 beats (2 BURST cycles).
- R6: The mask for beat k is the inverse of `req_be[k]`, where 1 means write. A masked beat still occupies its strobe edge.
- R7: Cycle WL+BL/2 is the postamble. `dqs_oe_hi`=1, `dqs_oe_lo`=0, and both strobe halves are 0. Strobe and data are undriven in every other cycle outside R3 and R4.
- R8: PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0, `ba`=bank, `addr`=0) is issued in cycle WL+BL/2+TWR. That is exactly TWR clocks after the last beat completes, and never earlier.
- R9: `done` is 1 only in the PRECHARGE cycle. `req_ready` is 1 only in IDLE, from the cycle after PRECHARGE until the next acceptance. A request held valid while the block is busy is taken only once the block is ready.
- R10: Request inputs that change after acceptance do not affect the burst in progress.
- R11: While reset is held, the outputs are `req_ready`=1, NOP, all enables 0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_data | input | 8*DW | Eight data words, word k at bits k*DW |
| req_be | input | 8 | Per-beat write enable, 1 = write |
| req_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dqs_oe_hi | output | 1 | Strobe driven in first half-cycle |
| dqs_oe_lo | output | 1 | Strobe driven in second half-cycle |
| dqs_hi | output | 1 | Strobe level, first half |
| dqs_lo | output | 1 | Strobe level, second half |
| dq_oe | output | 1 | Data and mask driven |
| dq_rise | output | DW | Data on the rising strobe edge |
| dq_fall | output | DW | Data on the falling strobe edge |
| dm_rise | output | 1 | Mask on the rising strobe edge |
| dm_fall | output | 1 | Mask on the falling strobe edge |
| done | output | 1 | Write recovery over, precharge issued |

## Verification
The hardest situation to reach is a request that is already pending when the block becomes ready. The inputs must be held while they are ignored, and then taken in exactly the first idle cycle. The bench gets there by raising valid with a second request while the first burst is still in flight and holding it until it is accepted. The bench also rewrites the data, enables and bank lines just after the first acceptance, which shows that the beats come from the captured copy. A reference model in the bench tracks every cycle from reset against AL, CL, the burst length and TWR, and compares every output on every clock.

// File: rtl/ddr2_wr_pkg.sv
package ddr2_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRCMD,
        ST_WAIT,
        ST_PREAMB,
        ST_BURST,
        ST_POSTAM,
        ST_RECOV,
        ST_PCHG
    } wr_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

    localparam int MAX_BEATS = 8;

endpackage

// File: rtl/ddr2_wr_fsm.sv
module ddr2_wr_fsm
    import ddr2_wr_pkg::*;
#(
    parameter int WL  = 4,
    parameter int TWR = 3,
    parameter int PW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             bl8,
    output wr_state_t        state,
    output logic [PW-1:0]    pair,
    output logic             ready,
    output logic             done
);
    localparam int CMAX     = (WL > TWR) ? WL : TWR;
    localparam int CW       = $clog2(CMAX + 1);
    localparam int WAIT_CYC = WL - 2;

    wr_state_t       state_nx;
    logic [CW-1:0]   cnt, cnt_nx;
    logic [PW-1:0]   pair_nx;
    logic [PW-1:0]   last_pair;

    assign last_pair = bl8 ? PW'(MAX_BEATS / 2 - 1) : PW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pair  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            pair  <= pair_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        pair_nx  = pair;
        unique case (state)
            ST_IDLE:   if (fire) state_nx = ST_WRCMD;
            ST_WRCMD: begin
                if (WAIT_CYC == 0) begin
                    state_nx = ST_PREAMB;
                end else begin
                    state_nx = ST_WAIT;
                    cnt_nx   = CW'(WAIT_CYC - 1);
                end
            end
            ST_WAIT: begin
                if (cnt == '0) state_nx = ST_PREAMB;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_PREAMB: begin
                state_nx = ST_BURST;
                pair_nx  = '0;
            end
            ST_BURST: begin
                if (pair == last_pair) state_nx = ST_POSTAM;
                else                   pair_nx  = pair + 1'b1;
            end
            ST_POSTAM: begin
                if (TWR <= 1) begin
                    state_nx = ST_PCHG;
                end else begin
                    state_nx = ST_RECOV;
                    cnt_nx   = CW'(TWR - 2);
                end
            end
            ST_RECOV: begin
                if (cnt == '0) state_nx = ST_PCHG;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_PCHG:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign ready = (state == ST_IDLE);
    assign done  = (state == ST_PCHG);
endmodule

// File: rtl/ddr2_wr_cmd_enc.sv
module ddr2_wr_cmd_enc
    import ddr2_wr_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 14
) (
    input  wr_state_t          state,
    input  logic [BANK_W-1:0]  bank,
    input  logic [COL_W-1:0]   col,
    output cmd_pins_t          pins,
    output logic [BANK_W-1:0]  ba,
    output logic [ADDR_W-1:0]  addr
);
    // output process: command pins follow the state
    always_comb begin
        pins = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_WRCMD: begin
                pins             = CMD_WRITE;
                ba               = bank;
                addr[COL_W-1:0]  = col;
                addr[10]         = 1'b0;   // no auto-precharge
            end
            ST_PCHG: begin
                pins = CMD_PRE;
                ba   = bank;               // addr[10]=0: one bank only
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_wr_beat_sel.sv
module ddr2_wr_beat_sel
    import ddr2_wr_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 2
) (
    input  wr_state_t                 state,
    input  logic [PW-1:0]             pair,
    input  logic [MAX_BEATS*DW-1:0]   data,
    input  logic [MAX_BEATS-1:0]      be,
    output logic                      dqs_oe_hi,
    output logic                      dqs_oe_lo,
    output logic                      dqs_hi,
    output logic                      dqs_lo,
    output logic                      dq_oe,
    output logic [DW-1:0]             dq_rise,
    output logic [DW-1:0]             dq_fall,
    output logic                      dm_rise,
    output logic                      dm_fall
);
    logic [DW-1:0] word [MAX_BEATS];

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_word
        assign word[g] = data[g*DW +: DW];
    end

    logic [PW:0] even_idx, odd_idx;
    assign even_idx = {pair, 1'b0};
    assign odd_idx  = {pair, 1'b1};

    // output process: strobe and data per half-cycle
    always_comb begin
        dqs_oe_hi = 1'b0;
        dqs_oe_lo = 1'b0;
        dqs_hi    = 1'b0;
        dqs_lo    = 1'b0;
        dq_oe     = 1'b0;
        dq_rise   = '0;
        dq_fall   = '0;
        dm_rise   = 1'b0;
        dm_fall   = 1'b0;
        unique case (state)
            ST_PREAMB: begin
                dqs_oe_hi = 1'b1;
                dqs_oe_lo = 1'b1;
            end
            ST_BURST: begin
                dqs_oe_hi = 1'b1;
                dqs_oe_lo = 1'b1;
                dqs_hi    = 1'b1;
                dq_oe     = 1'b1;
                dq_rise   = word[even_idx];
                dq_fall   = word[odd_idx];
                dm_rise   = ~be[even_idx];
                dm_fall   = ~be[odd_idx];
            end
            ST_POSTAM: dqs_oe_hi = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_wr_seq.sv
module ddr2_wr_seq
    import ddr2_wr_pkg::*;
#(
    parameter int AL     = 2,
    parameter int CL     = 3,
    parameter int TWR    = 3,
    parameter int DW     = 16,
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [COL_W-1:0]          req_col,
    input  logic [MAX_BEATS*DW-1:0]   req_data,
    input  logic [MAX_BEATS-1:0]      req_be,
    input  logic                      req_bl8,
    output logic                      cs_n,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      we_n,
    output logic [BANK_W-1:0]         ba,
    output logic [ADDR_W-1:0]         addr,
    output logic                      dqs_oe_hi,
    output logic                      dqs_oe_lo,
    output logic                      dqs_hi,
    output logic                      dqs_lo,
    output logic                      dq_oe,
    output logic [DW-1:0]             dq_rise,
    output logic [DW-1:0]             dq_fall,
    output logic                      dm_rise,
    output logic                      dm_fall,
    output logic                      done
);
    localparam int WL = AL + CL - 1;
    localparam int PW = $clog2(MAX_BEATS / 2);

    wr_state_t                 state;
    logic [PW-1:0]             pair;
    logic                      fire;
    logic [BANK_W-1:0]         bank_q;
    logic [COL_W-1:0]          col_q;
    logic [MAX_BEATS*DW-1:0]   data_q;
    logic [MAX_BEATS-1:0]      be_q;
    logic                      bl8_q;
    cmd_pins_t                 pins;

    assign fire = req_valid && req_ready;

    // request capture: later input changes do not reach the burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            data_q <= '0;
            be_q   <= '0;
            bl8_q  <= 1'b0;
        end else if (fire) begin
            bank_q <= req_bank;
            col_q  <= req_col;
            data_q <= req_data;
            be_q   <= req_be;
            bl8_q  <= req_bl8;
        end
    end

    ddr2_wr_fsm #(.WL(WL), .TWR(TWR), .PW(PW)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .bl8   (bl8_q),
        .state (state),
        .pair  (pair),
        .ready (req_ready),
        .done  (done)
    );

    ddr2_wr_cmd_enc #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_cmd (
        .state (state),
        .bank  (bank_q),
        .col   (col_q),
        .pins  (pins),
        .ba    (ba),
        .addr  (addr)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

    ddr2_wr_beat_sel #(.DW(DW), .PW(PW)) u_beat (
        .state     (state),
        .pair      (pair),
        .data      (data_q),
        .be        (be_q),
        .dqs_oe_hi (dqs_oe_hi),
        .dqs_oe_lo (dqs_oe_lo),
        .dqs_hi    (dqs_hi),
        .dqs_lo    (dqs_lo),
        .dq_oe     (dq_oe),
        .dq_rise   (dq_rise),
        .dq_fall   (dq_fall),
        .dm_rise   (dm_rise),
        .dm_fall   (dm_fall)
    );
endmodule

// File: rtl/ddr2_wr_seq_chk.sv
module ddr2_wr_seq_chk #(
    parameter int AL  = 2,
    parameter int CL  = 3,
    parameter int TWR = 3
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic dqs_oe_hi,
    input logic dqs_oe_lo,
    input logic dqs_hi,
    input logic dqs_lo
);
    localparam int WL  = AL + CL - 1;
    localparam int SAT = 1000;

    logic wr_cmd, pre_cmd;
    assign wr_cmd  = !cs_n && ras_n && !cas_n && !we_n;
    assign pre_cmd = !cs_n && !ras_n && cas_n && !we_n;

    int   age;
    logic age_act;
    int   gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age     <= 0;
            age_act <= 1'b0;
            gap     <= 0;
        end else begin
            if (wr_cmd) begin
                age_act <= 1'b1;
                age     <= 1;
            end else if (age_act && age < SAT) begin
                age <= age + 1;
            end
            if (dq_oe)                 gap <= 1;
            else if (gap > 0 && gap < SAT) gap <= gap + 1;
        end
    end

    assert_write_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |-> $past(req_valid && req_ready));

    assert_chip_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n);

    assert_preamble_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_act && age == WL - 1) |-> (dqs_oe_hi && dqs_oe_lo && !dqs_hi && !dqs_lo && !dq_oe));

    assert_beat_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqs_oe_hi && dqs_oe_lo && dqs_hi && !dqs_lo));

    assert_postamble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (dqs_oe_hi && !dqs_oe_lo && !dqs_hi && !dqs_lo));

    assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cmd |-> (gap > TWR));

    assert_done_with_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pre_cmd);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!dq_oe && !dqs_oe_hi && !dqs_oe_lo));
endmodule

bind ddr2_wr_seq ddr2_wr_seq_chk #(.AL(AL), .CL(CL), .TWR(TWR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .dqs_oe_hi (dqs_oe_hi),
    .dqs_oe_lo (dqs_oe_lo),
    .dqs_hi    (dqs_hi),
    .dqs_lo    (dqs_lo)
);

// File: tb/sim_ddr2_wr_seq.sv
`timescale 1ns/1ps
module sim_ddr2_wr_seq;
    localparam int AL = 2, CL = 3, TWR = 3, DW = 16;
    localparam int BANK_W = 3, COL_W = 10, ADDR_W = 14, NB = 8;
    localparam int WL = AL + CL - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [BANK_W-1:0]    req_bank = '0;
    logic [COL_W-1:0]     req_col = '0;
    logic [NB*DW-1:0]     req_data = '0;
    logic [NB-1:0]        req_be = '0;
    logic                 req_bl8 = 1'b0;
    logic cs_n, ras_n, cas_n, we_n;
    logic [BANK_W-1:0]    ba;
    logic [ADDR_W-1:0]    addr;
    logic dqs_oe_hi, dqs_oe_lo, dqs_hi, dqs_lo, dq_oe, dm_rise, dm_fall, done;
    logic [DW-1:0]        dq_rise, dq_fall;

    ddr2_wr_seq #(.AL(AL), .CL(CL), .TWR(TWR), .DW(DW), .BANK_W(BANK_W),
                  .COL_W(COL_W), .ADDR_W(ADDR_W)) u0 (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, got, exp);
        end
    endtask

    // reference model state
    logic              m_busy = 1'b0;
    int                m_t = 0;
    logic              m_fire_prev = 1'b0;
    logic [BANK_W-1:0] s_bank, m_bank;
    logic [COL_W-1:0]  s_col, m_col;
    logic [NB*DW-1:0]  s_data, m_data;
    logic [NB-1:0]     s_be, m_be;
    logic              s_bl8, m_bl8;
    int                beat_cycles = 0;

    always @(negedge clk) begin
        int bl, tot, i;
        logic [3:0] e_cmd;
        logic [BANK_W-1:0] e_ba;
        logic [ADDR_W-1:0] e_addr;
        logic [3:0] e_dqs;
        logic e_dqoe, e_dmr, e_dmf;
        logic [DW-1:0] e_dr, e_df;
        string tc, ts;
        if (!rst_n) begin
            m_busy = 1'b0;
        end else if (m_fire_prev) begin
            m_busy = 1'b1; m_t = 0;
            m_bank = s_bank; m_col = s_col; m_data = s_data; m_be = s_be; m_bl8 = s_bl8;
        end else if (m_busy) begin
            m_t++;
        end
        bl  = m_bl8 ? 8 : 4;
        tot = WL + bl / 2 + TWR;
        if (m_busy && m_t > tot) m_busy = 1'b0;

        e_cmd = 4'b0111; e_ba = '0; e_addr = '0; e_dqs = 4'b0000;
        e_dqoe = 0; e_dr = '0; e_df = '0; e_dmr = 0; e_dmf = 0;
        tc = rst_n ? "R2" : "R11"; ts = rst_n ? "R7" : "R11";
        if (m_busy) begin
            if (m_t == 0) begin
                e_cmd = 4'b0100; e_ba = m_bank; e_addr[COL_W-1:0] = m_col; tc = "R1";
            end else if (m_t == tot) begin
                e_cmd = 4'b0010; e_ba = m_bank; tc = "R8";
            end
            if (m_t == WL - 1) begin
                e_dqs = 4'b1100; ts = "R3";
            end else if (m_t >= WL && m_t < WL + bl / 2) begin
                i = m_t - WL;
                e_dqs = 4'b1110; ts = "R4"; e_dqoe = 1;
                e_dr = m_data[2*i*DW +: DW]; e_df = m_data[(2*i+1)*DW +: DW];
                e_dmr = ~m_be[2*i]; e_dmf = ~m_be[2*i+1];
            end else if (m_t == WL + bl / 2) begin
                e_dqs = 4'b1000; ts = "R7";
            end
        end
        check(tc, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
        check(tc, "ba", ba, e_ba);
        check(tc, "addr", addr, e_addr);
        check(ts, "dqs", {dqs_oe_hi, dqs_oe_lo, dqs_hi, dqs_lo}, e_dqs);
        check(rst_n ? "R4" : "R11", "dq_oe", dq_oe, e_dqoe);
        check("R4", "dq_rise", dq_rise, e_dr);
        check("R4", "dq_fall", dq_fall, e_df);
        check("R6", "dm", {dm_rise, dm_fall}, {e_dmr, e_dmf});
        check(rst_n ? "R9" : "R11", "ready", req_ready, !m_busy);
        check(rst_n ? "R9" : "R11", "done", done, m_busy && m_t == tot);
        if (dq_oe) beat_cycles++;

        m_fire_prev = rst_n && req_valid && !m_busy;
        s_bank = req_bank; s_col = req_col; s_data = req_data; s_be = req_be; s_bl8 = req_bl8;
    end

    task automatic send(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c,
                        input logic [NB*DW-1:0] d, input logic [NB-1:0] e, input logic l8);
        logic r;
        @(posedge clk); #1;
        req_valid = 1; req_bank = b; req_col = c; req_data = d; req_be = e; req_bl8 = l8;
        do begin
            @(negedge clk); r = req_ready;
            @(posedge clk);
        end while (!r);
        #1 req_valid = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NB*DW-1:0] d1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        repeat (2) @(posedge clk);

        // BL4, all beats written (R1 R3 R4 R7 R8)
        beat_cycles = 0;
        send(3'd2, 10'h155, 128'h8888_7777_6666_5555_4444_3333_2222_1111, 8'hFF, 1'b0);
        wait_done();
        check("R5", "bl4 beat cycles", beat_cycles, 2);

        // BL8 with masks (R5 R6)
        beat_cycles = 0;
        send(3'd5, 10'h3FF, 128'hF0F0_E1E1_D2D2_C3C3_B4B4_A5A5_9696_8787, 8'b1010_0110, 1'b1);
        wait_done();
        check("R5", "bl8 beat cycles", beat_cycles, 4);

        // inputs changed right after acceptance (R10)
        d1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        send(3'd7, 10'h0A5, d1, 8'h0F, 1'b1);
        req_data = '1; req_be = '0; req_bank = '0; req_bl8 = 1'b0;
        do @(negedge clk); while (!dq_oe);
        check("R10", "first beat", dq_rise, d1[DW-1:0]);
        check("R10", "first mask", dm_rise, 1'b0);
        wait_done();

        // request held while busy, taken on first idle cycle (R9)
        send(3'd1, 10'h001, 128'h1, 8'h01, 1'b0);
        send(3'd6, 10'h200, 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_1234_5678, 8'hC3, 1'b1);
        wait_done();
        repeat (4) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule